// File: doc/BRIEF.md
# GPI Event Routing Controller

This block takes sixteen general-purpose inputs and turns their events into system-level requests. Each input has a sticky status flag. The flag is set when the synchronized pin shows a rising edge while that pin is configured as an input. Software clears it by writing a one to it. A 32-bit route register gives each input a 2-bit code. The code sends that input's event to the system management interrupt (SMI), to the system control interrupt (SCI), or to neither.

Each route is also qualified by a per-input enable: an SMI enable for the SMI path and a general-purpose-event enable for the SCI path. Pins configured as outputs never contribute to SMI or SCI. A separate wake path does not look at the route code. It raises a wake request whenever the platform is sleeping and an enabled input has its flag set. That path is silenced when the platform reached its deepest sleep state through a forced power-button shutdown.

Software reaches both registers through one simple port: a write strobe, a select bit, write data, and combinational read data. The block holds no state machine. Sleep state arrives as an encoded input and is decoded into a single wake-permit signal.

Top module: `gpi_event_router`

## Requirements
- R1: With `reg_sel`=0, a write loads the route register and a read returns it; input i owns bits 2i+1:2i.
- R2: After reset the route register and all status flags read 0, `smi_n` is 1, and `sci` and `wake_req` are 0.
- R3: Route code 00 selects nothing, 01 selects SMI, 10 selects SCI, and 11 (reserved) selects neither output.
- R4: An SMI-routed input drives the SMI request only while its status flag and its `smi_en` bit are both 1. An SCI-routed input drives the SCI request only while its status flag and its `gpe_en` bit are both 1.
- R5: When `gpi_is_input[i]` is 0, input i's route code has no effect on `smi_n` or `sci`, and edges on its pin do not set its status flag.
- R6: A rising edge on `gpi_pin[i]` while it is an input sets status flag i. The pin passes through a two-flop synchronizer, so the flag is visible three clock edges after the pin rises. With `reg_sel`=1, flags read back on bits 15:0.
- R7: A write with `reg_sel`=1 clears each status flag whose data bit is 1 and leaves the flags written with 0 unchanged.
- R8: `smi_n` is the active-low OR of all per-input SMI requests, and `sci` is the active-high OR of all per-input SCI requests.
- R9: When `sleep_state` is 1 to 5, any input with its status flag and `gpe_en` bit set raises `wake_req`, whatever its route code or direction. Sleep states 0, 6 and 7 never raise it.
- R10: When `sleep_state` is 5 and `pwrbtn_ovr` is 1, `wake_req` stays 0. In states 1 to 4, `pwrbtn_ovr` has no effect.
- R11: Rewriting a route field while its status flag is already set changes `smi_n`/`sci` right after the write's clock edge, with no new pin event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gpi_pin | input | 16 | Raw general-purpose input levels |
| gpi_is_input | input | 16 | 1 = pin configured as input |
| smi_en | input | 16 | Per-input SMI enable |
| gpe_en | input | 16 | Per-input general-purpose-event enable (SCI and wake) |
| sleep_state | input | 3 | 0 = running, 1..5 = sleep states S1..S5 |
| pwrbtn_ovr | input | 1 | Current S5 was entered by power-button override |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = route register, 1 = status register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| smi_n | output | 1 | Aggregated SMI request, active low |
| sci | output | 1 | Aggregated SCI request |
| wake_req | output | 1 | Wake request |

## Verification
For one input with its flag set, the bench sweeps every combination of the four route codes, direction, SMI enable and event enable. It also sweeps all eight sleep encodings with the override flag on and off. A decoder that treats the reserved code as SMI or SCI, ignores direction, or lets the override silence S1 to S4 produces a wrong output level in one of these cells. Further tests check that write-one-to-clear spares the bits written with zero, that an output pin's edge leaves its flag alone, and that a route rewrite on an already-set flag changes the outputs one edge later. A design that clears the whole register, latches edges from output pins, or waits for a fresh event fails these tests. OR aggregation is exercised with two simultaneous SMI sources, one of which is then cleared.

// File: rtl/gpi_route_pkg.sv
package gpi_route_pkg;
    localparam int ROUTE_W = 2;

    typedef enum logic [ROUTE_W-1:0] {
        RT_OFF  = 2'b00,
        RT_SMI  = 2'b01,
        RT_SCI  = 2'b10,
        RT_RSVD = 2'b11
    } route_e;

    typedef enum logic [2:0] {
        PS_RUN = 3'd0,
        PS_S1  = 3'd1,
        PS_S2  = 3'd2,
        PS_S3  = 3'd3,
        PS_S4  = 3'd4,
        PS_S5  = 3'd5
    } pstate_e;
endpackage

// File: rtl/gpi_sync_edge.sv
module gpi_sync_edge #(
    parameter int N      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin,
    input  logic [N-1:0] is_input,
    output logic [N-1:0] rise
);
    logic [N-1:0] sync_q [STAGES];
    logic [N-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) sync_q[k] <= '0;
            prev_q <= '0;
        end else begin
            sync_q[0] <= pin;
            for (int k = 1; k < STAGES; k++) sync_q[k] <= sync_q[k-1];
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign rise = sync_q[STAGES-1] & ~prev_q & is_input;
endmodule

// File: rtl/gpi_route_regs.sv
module gpi_route_regs
    import gpi_route_pkg::*;
#(
    parameter int N  = 16,
    parameter int DW = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         set_evt,
    input  logic                 reg_wr,
    input  logic                 reg_sel,
    input  logic [DW-1:0]        reg_wdata,
    output logic [N*ROUTE_W-1:0] route_q,
    output logic [N-1:0]         status_q
);
    localparam int RW = N * ROUTE_W;

    logic         wr_route, wr_status;
    logic [N-1:0] clr_mask;

    assign wr_route  = reg_wr && !reg_sel;
    assign wr_status = reg_wr &&  reg_sel;
    assign clr_mask  = wr_status ? reg_wdata[N-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            route_q  <= '0;
            status_q <= '0;
        end else begin
            if (wr_route) route_q <= reg_wdata[RW-1:0];
            status_q <= (status_q & ~clr_mask) | set_evt;
        end
    end

    // R7: a written one clears its flag unless an edge arrives in the same cycle
    a_r7_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        wr_status |=> ((status_q & $past(reg_wdata[N-1:0] & ~set_evt)) == '0));

    // R6: flags are sticky without a status write
    a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_status |=> ((status_q & $past(status_q)) == $past(status_q)));
endmodule

// File: rtl/gpi_route_gate.sv
module gpi_route_gate
    import gpi_route_pkg::*;
#(
    parameter int N = 16
) (
    input  logic [N*ROUTE_W-1:0] route,
    input  logic [N-1:0]         status,
    input  logic [N-1:0]         is_input,
    input  logic [N-1:0]         smi_en,
    input  logic [N-1:0]         gpe_en,
    output logic                 smi_any,
    output logic                 sci_any,
    output logic                 wake_any
);
    logic [N-1:0] smi_hit, sci_hit;

    for (genvar i = 0; i < N; i++) begin : g_in
        route_e rc;
        logic   live;
        assign rc   = route_e'(route[i*ROUTE_W +: ROUTE_W]);
        assign live = status[i] && is_input[i];
        always_comb begin
            smi_hit[i] = 1'b0;
            sci_hit[i] = 1'b0;
            unique case (rc)
                RT_SMI:  smi_hit[i] = live && smi_en[i];
                RT_SCI:  sci_hit[i] = live && gpe_en[i];
                RT_OFF,
                RT_RSVD: ;
                default: ;
            endcase
        end
    end

    assign smi_any  = |smi_hit;
    assign sci_any  = |sci_hit;
    assign wake_any = |(status & gpe_en);
endmodule

// File: rtl/gpi_event_router.sv
module gpi_event_router
    import gpi_route_pkg::*;
#(
    parameter int N      = 16,
    parameter int DW     = 32,
    parameter int STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  gpi_pin,
    input  logic [N-1:0]  gpi_is_input,
    input  logic [N-1:0]  smi_en,
    input  logic [N-1:0]  gpe_en,
    input  logic [2:0]    sleep_state,
    input  logic          pwrbtn_ovr,
    input  logic          reg_wr,
    input  logic          reg_sel,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          smi_n,
    output logic          sci,
    output logic          wake_req
);
    localparam int RW = N * ROUTE_W;

    logic [N-1:0]  rise, status_q;
    logic [RW-1:0] route_q;
    logic          smi_any, sci_any, wake_any, wake_ok;

    gpi_sync_edge #(.N(N), .STAGES(STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin(gpi_pin),
        .is_input(gpi_is_input), .rise(rise)
    );

    gpi_route_regs #(.N(N), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .set_evt(rise),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .route_q(route_q), .status_q(status_q)
    );

    gpi_route_gate #(.N(N)) u_gate (
        .route(route_q), .status(status_q), .is_input(gpi_is_input),
        .smi_en(smi_en), .gpe_en(gpe_en),
        .smi_any(smi_any), .sci_any(sci_any), .wake_any(wake_any)
    );

    always_comb begin
        wake_ok = 1'b0;
        case (sleep_state)
            PS_S1, PS_S2, PS_S3, PS_S4: wake_ok = 1'b1;
            PS_S5:                      wake_ok = !pwrbtn_ovr;
            default:                    wake_ok = 1'b0;
        endcase
    end

    assign smi_n     = !smi_any;
    assign sci       = sci_any;
    assign wake_req  = wake_any && wake_ok;
    assign reg_rdata = reg_sel ? DW'(status_q) : DW'(route_q);

    // R9: never wake while running
    a_r9_no_wake_run: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_state == 3'd0) |-> !wake_req);

    // R10: forced shutdown blocks wake
    a_r10_pbo_s5: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_state == 3'd5 && pwrbtn_ovr) |-> !wake_req);

    // R8: SMI request needs a live, enabled flag somewhere
    a_r8_smi_source: assert property (@(posedge clk) disable iff (!rst_n)
        !smi_n |-> |(status_q & gpi_is_input & smi_en));

    // R4: SCI request needs a live flag with event enable
    a_r4_sci_gated: assert property (@(posedge clk) disable iff (!rst_n)
        sci |-> |(status_q & gpi_is_input & gpe_en));
endmodule

// File: tb/sim_gpi_event_router.sv
module sim_gpi_event_router;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] gpi_pin = '0, gpi_is_input = '0, smi_en = '0, gpe_en = '0;
    logic [2:0]  sleep_state = '0;
    logic        pwrbtn_ovr = 1'b0, reg_wr = 1'b0, reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        smi_n, sci, wake_req;
    int n_cmp = 0, n_bad = 0;

    always #4 clk = ~clk;

    gpi_event_router u0 (
        .clk(clk), .rst_n(rst_n), .gpi_pin(gpi_pin), .gpi_is_input(gpi_is_input),
        .smi_en(smi_en), .gpe_en(gpe_en), .sleep_state(sleep_state),
        .pwrbtn_ovr(pwrbtn_ovr), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .smi_n(smi_n), .sci(sci), .wake_req(wake_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [31:0] d);
        @(negedge clk);
        reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        #1;
    endtask

    task automatic rd(input logic sel, output logic [31:0] d);
        reg_sel = sel;
        #1 d = reg_rdata;
    endtask

    task automatic pulse(input int i);
        @(negedge clk);
        gpi_pin[i] = 1'b1;
        repeat (3) @(negedge clk);
        gpi_pin[i] = 1'b0;
        repeat (3) @(negedge clk);
        #1;
    endtask

    function automatic logic [31:0] route_word(input int i, input logic [1:0] c);
        return 32'(c) << (2 * i);
    endfunction

    initial begin : wd
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R2 reset state
        rd(1'b0, d); chk("R2 route", d, 32'h0);
        rd(1'b1, d); chk("R2 status", d, 32'h0);
        chk("R2 smi_n", 32'(smi_n), 32'h1);
        chk("R2 sci", 32'(sci), 32'h0);
        chk("R2 wake", 32'(wake_req), 32'h0);

        // R1 layout and readback
        wr(1'b0, 32'hA5C3_1E96);
        rd(1'b0, d); chk("R1 readback", d, 32'hA5C3_1E96);
        wr(1'b0, route_word(15, 2'b11));
        rd(1'b0, d); chk("R1 top field", d, 32'hC000_0000);
        wr(1'b0, 32'h0);

        // R6 latch on input pin 3, R5 output pin 5 ignored
        gpi_is_input = 16'hFFDF;
        pulse(3);
        rd(1'b1, d); chk("R6 status set", d, 32'h0000_0008);
        pulse(5);
        rd(1'b1, d); chk("R5 output pin no latch", d, 32'h0000_0008);

        // R3 R4 R5 exhaustive sweep for input 3
        for (int rt = 0; rt < 4; rt++) begin
            wr(1'b0, route_word(3, 2'(rt)));
            for (int m = 0; m < 8; m++) begin
                logic isin, se, ge, es, ec;
                isin = m[0]; se = m[1]; ge = m[2];
                gpi_is_input[3] = isin; smi_en[3] = se; gpe_en[3] = ge;
                #1;
                es = isin && se && (rt == 1);
                ec = isin && ge && (rt == 2);
                chk($sformatf("R3 R4 R5 smi rt=%0d m=%0d", rt, m), 32'(smi_n), 32'(!es));
                chk($sformatf("R3 R4 R5 sci rt=%0d m=%0d", rt, m), 32'(sci), 32'(ec));
            end
        end

        // R9 R10 sleep sweep, route 00
        wr(1'b0, 32'h0);
        gpi_is_input[3] = 1'b0;
        for (int s = 0; s < 8; s++) begin
            for (int m = 0; m < 4; m++) begin
                logic ew;
                pwrbtn_ovr = m[0]; gpe_en[3] = m[1]; sleep_state = 3'(s);
                #1;
                ew = m[1] && (s >= 1 && s <= 5) && !(s == 5 && m[0]);
                chk($sformatf("R9 R10 wake s=%0d m=%0d", s, m), 32'(wake_req), 32'(ew));
            end
        end
        sleep_state = 3'd0; pwrbtn_ovr = 1'b0;
        gpi_is_input = 16'hFFFF; smi_en = 16'hFFFF; gpe_en = '0;

        // R11 route rewrite on a set flag
        chk("R11 before", 32'(smi_n), 32'h1);
        wr(1'b0, route_word(3, 2'b01));
        chk("R11 after write", 32'(smi_n), 32'h0);

        // R8 aggregation with two SMI sources
        pulse(12);
        wr(1'b0, route_word(3, 2'b01) | route_word(12, 2'b01));
        chk("R8 two sources", 32'(smi_n), 32'h0);

        // R7 clear input 3 only
        wr(1'b1, 32'h0000_0008);
        rd(1'b1, d); chk("R7 selective clear", d, 32'h0000_1000);
        chk("R8 remaining source", 32'(smi_n), 32'h0);
        wr(1'b1, 32'h0000_0000);
        rd(1'b1, d); chk("R7 zero write keeps", d, 32'h0000_1000);
        wr(1'b1, 32'h0000_1000);
        chk("R8 no source", 32'(smi_n), 32'h1);
        rd(1'b1, d); chk("R7 all clear", d, 32'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule